// File: doc/BRIEF.md
# Two-Phase Microcoded-Free 16-bit Processor Core

This block is a very small 16-bit processor that spends exactly two clock cycles on every instruction: one fetch cycle and one execute cycle. There is no opcode decoder. Each instruction word is itself the control word for the datapath. Its fields are the memory read and write strobes, the register that drives the address bus and ALU input A, the register that drives the data bus and ALU input B, an active-low flag latch enable, a carry-in select and a five-bit ALU function. Fetch works the same way. During fetch the core applies a fixed control word, 16'hBF80. That word reads memory at register 7, which is the program counter, places the read word in the instruction register, and writes R7 plus one back into R7.

The core talks to a synchronous memory/IO port that returns read data in the same cycle. A read in execute loads the data word into the data-select register. This gives immediate loads through R7 and absolute jumps. A write sends the data-select register to the address held in the address-select register. A jump is a move into R7. In logic mode the carry-in select has no arithmetic use, so it gates the write-back instead. This provides conditional jumps and compares that leave the operand unchanged.

Top module: `mini_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the core is in the fetch phase, drives mem_addr = 0 with mem_rd = 1 and mem_wr = 0, and every register is zero.
- R2: Fetch and execute alternate on every cycle. A fetch reads at R7, loads the instruction register and leaves R7 incremented by one, so execute sees R7 pointing at the word after the instruction.
- R3: The control word layout is: bit 15 read, bit 14 write, bits 13:11 A select, bits 10:8 B select, bit 7 flag latch (active low), bits 6:5 carry select, bits 4:0 function. An execute-phase read writes mem_rdata into the B-select register. When that register is also the A-select register, the loaded data takes priority over the ALU result.
- R4: An execute-phase write drives mem_wr = 1, mem_addr = A-select register and mem_wdata = B-select register. The ALU result is still written back to the A-select register.
- R5: With bit 4 = 0 (arithmetic), function 0 gives A+cin, function 1 gives A+B+cin, and function 2 gives A+~B+cin (A−B when cin = 1). The result goes to the A-select register.
- R6: With bit 4 = 1 (logic), function 0x10 is A AND B, 0x11 is A OR B, 0x12 is A XOR B, 0x13 is NOT A and 0x14 passes B.
- R7: In arithmetic mode the carry select picks cin: 00 gives 1, 01 gives the CY flag, 10 gives the EQ flag and 11 gives 0.
- R8: When bit 7 is 0, CY takes the adder carry-out (0 in logic mode) and EQ takes "result is zero". When bit 7 is 1, both flags hold their values.
- R9: In logic mode the carry select gates write-back: 00 always writes, 01 writes only if CY = 1, 10 writes only if EQ = 1, and 11 never writes, so flags can be set without changing A.
- R10: A move or load into R7 redirects the next fetch to the new value. A conditional move into R7 whose condition is false lets execution continue at the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| mem_addr | output | 16 | Address, the value of the A-select register |
| mem_wdata | output | 16 | Write data, the value of the B-select register |
| mem_rd | output | 1 | Memory/IO read strobe |
| mem_wr | output | 1 | Memory/IO write strobe |
| fetch_phase | output | 1 | High during the fetch cycle |

## Verification
The hardest case to reach from the ports is an instruction whose effect depends on flags left behind by an earlier instruction. Examples are a carry-selected increment after several non-latching instructions, or a conditional jump after a compare that must not have changed its operand. None of this state is visible directly. The stimulus is a single program with compare, latch, hold and conditional steps arranged in sequence, and each step ends in a post-incrementing store. Every flag outcome therefore appears as a value at a known address. Taken jumps land past trap words, and any wrong path through them produces a store the scoreboard does not expect.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int DW      = 16;
    localparam int IW      = 16;
    localparam int REG_N   = 8;
    localparam int SEL_W   = $clog2(REG_N);
    localparam int FN_W    = 5;
    localparam int PC_IDX  = REG_N - 1;

    localparam logic [IW-1:0] FETCH_WORD = 16'hBF80;

    typedef enum logic [1:0] {
        CIN_ONE  = 2'b00,
        CIN_CY   = 2'b01,
        CIN_EQ   = 2'b10,
        CIN_ZERO = 2'b11
    } cin_sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [SEL_W-1:0] asel;
        logic [SEL_W-1:0] bsel;
        logic             latch_n;
        cin_sel_e         cin;
        logic [FN_W-1:0]  fn;
    } ctrl_t;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic cy;
        logic eq;
    } flags_t;

    localparam logic [3:0] AR_INC  = 4'h0;
    localparam logic [3:0] AR_ADD  = 4'h1;
    localparam logic [3:0] AR_SUB  = 4'h2;
    localparam logic [3:0] LG_AND  = 4'h0;
    localparam logic [3:0] LG_OR   = 4'h1;
    localparam logic [3:0] LG_XOR  = 4'h2;
    localparam logic [3:0] LG_NOTA = 4'h3;
    localparam logic [3:0] LG_PASB = 4'h4;

    function automatic logic pick_cin(cin_sel_e sel, flags_t f);
        case (sel)
            CIN_ONE:  return 1'b1;
            CIN_CY:   return f.cy;
            CIN_EQ:   return f.eq;
            default:  return 1'b0;
        endcase
    endfunction

    // Logic mode reuses the carry select as a write-back condition.
    function automatic logic wb_allowed(ctrl_t c, flags_t f);
        if (!c.fn[FN_W-1]) return 1'b1;
        case (c.cin)
            CIN_ONE:  return 1'b1;
            CIN_CY:   return f.cy;
            CIN_EQ:   return f.eq;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            cin_i,
    input  logic [FN_W-1:0] fn_i,
    output logic [W-1:0]    y_o,
    output logic            cout_o
);
    logic [W-1:0] opnd;
    logic [W:0]   sum;
    logic [W-1:0] lres;

    always_comb begin
        case (fn_i[3:0])
            AR_ADD:  opnd = b_i;
            AR_SUB:  opnd = ~b_i;
            default: opnd = '0;
        endcase
        sum = {1'b0, a_i} + {1'b0, opnd} + {{W{1'b0}}, cin_i};
    end

    always_comb begin
        case (fn_i[3:0])
            LG_AND:  lres = a_i & b_i;
            LG_OR:   lres = a_i | b_i;
            LG_XOR:  lres = a_i ^ b_i;
            LG_NOTA: lres = ~a_i;
            LG_PASB: lres = b_i;
            default: lres = a_i;
        endcase
    end

    assign y_o    = fn_i[FN_W-1] ? lres : sum[W-1:0];
    assign cout_o = fn_i[FN_W-1] ? 1'b0 : sum[W];

endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int W = DW,
    parameter int N = REG_N,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_sel_i,
    input  logic [AW-1:0] rb_sel_i,
    output logic [W-1:0]  ra_o,
    output logic [W-1:0]  rb_o,
    input  logic          alu_we_i,
    input  logic [AW-1:0] alu_sel_i,
    input  logic [W-1:0]  alu_data_i,
    input  logic          ld_we_i,
    input  logic [AW-1:0] ld_sel_i,
    input  logic [W-1:0]  ld_data_i
);
    logic [W-1:0] regs [N];

    assign ra_o = regs[ra_sel_i];
    assign rb_o = regs[rb_sel_i];

    // Memory load port wins over the ALU port on the same register.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (ld_we_i && ld_sel_i == AW'(i))
                regs[i] <= ld_data_i;
            else if (alu_we_i && alu_sel_i == AW'(i))
                regs[i] <= alu_data_i;
        end
    end

    // R3: loaded data survives a same-register ALU write
    a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
        (ld_we_i && alu_we_i && ld_sel_i == alu_sel_i)
        |=> regs[$past(ld_sel_i)] == $past(ld_data_i));

    // R9: with no write enabled, the selected register keeps its value
    a_r9_no_write_holds: assert property (@(posedge clk) disable iff (rst)
        (!ld_we_i && !alu_we_i) |=> regs[$past(ra_sel_i)] == $past(ra_o));

endmodule

// File: rtl/core_seq.sv
module core_seq
    import core_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rdata_i,
    input  logic [W-1:0] alu_y_i,
    input  logic         alu_cout_i,
    output ctrl_t        ctrl_o,
    output logic         cin_o,
    output logic         alu_we_o,
    output logic         ld_we_o,
    output logic         fetch_o
);
    phase_e        phase;
    logic [IW-1:0] ir;
    flags_t        flags;

    assign fetch_o  = (phase == PH_FETCH);
    assign ctrl_o   = fetch_o ? ctrl_t'(FETCH_WORD) : ctrl_t'(ir);
    assign cin_o    = pick_cin(ctrl_o.cin, flags);
    assign alu_we_o = fetch_o ? 1'b1 : wb_allowed(ctrl_o, flags);
    assign ld_we_o  = !fetch_o && ctrl_o.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            ir    <= '0;
            flags <= '0;
        end else begin
            phase <= fetch_o ? PH_EXEC : PH_FETCH;
            if (fetch_o)
                ir <= rdata_i[IW-1:0];
            if (!ctrl_o.latch_n) begin
                flags.cy <= alu_cout_i;
                flags.eq <= (alu_y_i == '0);
            end
        end
    end

    // R2: phases alternate
    a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_EXEC));
    a_r2_exec_then_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_FETCH));

    // R8: flags hold while the latch bit is high
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.latch_n |=> $stable(flags));

    // R9: logic mode with select 11 never writes back
    a_r9_inhibit: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ir[4] && ir[6:5] == 2'b11) |-> !alu_we_o);

endmodule

// File: rtl/mini_core.sv
module mini_core
    import core_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         fetch_phase
);
    ctrl_t        ctrl;
    logic         cin;
    logic         alu_we;
    logic         ld_we;
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [W-1:0] alu_y;
    logic         alu_cout;

    core_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rdata_i    (mem_rdata),
        .alu_y_i    (alu_y),
        .alu_cout_i (alu_cout),
        .ctrl_o     (ctrl),
        .cin_o      (cin),
        .alu_we_o   (alu_we),
        .ld_we_o    (ld_we),
        .fetch_o    (fetch_phase)
    );

    core_regfile #(.W(W), .N(REG_N)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .ra_sel_i   (ctrl.asel),
        .rb_sel_i   (ctrl.bsel),
        .ra_o       (ra),
        .rb_o       (rb),
        .alu_we_i   (alu_we),
        .alu_sel_i  (ctrl.asel),
        .alu_data_i (alu_y),
        .ld_we_i    (ld_we),
        .ld_sel_i   (ctrl.bsel),
        .ld_data_i  (mem_rdata)
    );

    core_alu #(.W(W)) u_alu (
        .a_i    (ra),
        .b_i    (rb),
        .cin_i  (cin),
        .fn_i   (ctrl.fn),
        .y_o    (alu_y),
        .cout_o (alu_cout)
    );

    assign mem_addr  = ra;
    assign mem_wdata = rb;
    assign mem_rd    = ctrl.rd;
    assign mem_wr    = ctrl.wr;

    // R1: a fetch cycle reads and never writes
    a_r1_fetch_strobes: assert property (@(posedge clk) disable iff (rst)
        fetch_phase |-> (mem_rd && !mem_wr));

    // R2: the fetch address advances by one across a straight-line execute
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        fetch_phase |=> (mem_addr == $past(mem_addr) + W'(1)) || (ctrl.asel != 3'(PC_IDX)));

endmodule

// File: tb/mini_core_bench.sv
module mini_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_rd, mem_wr, fetch_phase;

    logic [15:0] mem [256];

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        string       req;
    } st_item_t;

    st_item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mini_core u_mini_core (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .fetch_phase(fetch_phase)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk)
        if (mem_wr === 1'b1) mem[mem_addr[7:0]] <= mem_wdata;

    function automatic logic [15:0] ins(bit rd, bit wr, int a, int b, bit ln, int cs, int fn);
        return {rd, wr, 3'(a), 3'(b), ln, 2'(cs), 5'(fn)};
    endfunction
    function automatic logic [15:0] ldi(int r);         return ins(1, 0, 7, r, 1, 0, 'h00); endfunction
    function automatic logic [15:0] mov(int a, int b, int cs); return ins(0, 0, a, b, 1, cs, 'h14); endfunction
    function automatic logic [15:0] st(int ar, int dr); return ins(0, 1, ar, dr, 1, 0, 'h00); endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_st(logic [15:0] a, logic [15:0] d, string req);
        st_item_t it;
        it.addr = a; it.data = d; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: every write strobe is compared with the next expected store
    always @(negedge clk) begin
        if (mem_wr === 1'b1 && !done) begin
            if (q.size() == 0) begin
                check("R10 unexpected store", mem_addr, 16'hxxxx);
            end else begin
                st_item_t it;
                it = q.pop_front();
                check({it.req, " addr"}, mem_addr, it.addr);
                check({it.req, " data"}, mem_wdata, it.data);
            end
        end
    end

    task automatic load_program();
        for (int i = 0; i < 256; i++) mem[i] = st(6, 1);  // trap word
        mem[0]  = ldi(1);                mem[1] = 16'h1234;
        mem[2]  = ldi(2);                mem[3] = 16'h0F0F;
        mem[4]  = ldi(6);                mem[5] = 16'h0080;
        mem[6]  = mov(3, 1, 0);
        mem[7]  = ins(0, 0, 3, 2, 0, 3, 'h01);   // add, cin 0, latch
        mem[8]  = st(6, 3);
        mem[9]  = mov(4, 1, 0);
        mem[10] = ins(0, 0, 4, 2, 1, 0, 'h10);   // and
        mem[11] = st(6, 4);
        mem[12] = mov(4, 1, 0);
        mem[13] = ins(0, 0, 4, 2, 1, 0, 'h11);   // or
        mem[14] = st(6, 4);
        mem[15] = mov(4, 1, 0);
        mem[16] = ins(0, 0, 4, 2, 1, 0, 'h12);   // xor
        mem[17] = st(6, 4);
        mem[18] = ins(0, 0, 4, 0, 1, 0, 'h13);   // not A
        mem[19] = st(6, 4);
        mem[20] = mov(5, 1, 0);
        mem[21] = ins(0, 0, 5, 2, 0, 0, 'h02);   // sub, latch: CY=1
        mem[22] = st(6, 5);
        mem[23] = mov(4, 2, 0);
        mem[24] = ins(0, 0, 4, 0, 1, 1, 'h00);   // A+CY, no latch
        mem[25] = st(6, 4);
        mem[26] = ins(0, 0, 4, 0, 1, 1, 'h00);   // CY still 1
        mem[27] = st(6, 4);
        mem[28] = ins(0, 0, 4, 0, 0, 3, 'h00);   // A+0, latch: CY=0 EQ=0
        mem[29] = ins(0, 0, 1, 1, 0, 3, 'h12);   // compare R1,R1: EQ=1
        mem[30] = ins(0, 0, 4, 0, 1, 2, 'h00);   // A+EQ
        mem[31] = ins(0, 0, 4, 0, 1, 1, 'h00);   // A+CY (0)
        mem[32] = st(6, 4);
        mem[33] = st(6, 1);
        mem[34] = mov(4, 2, 1);                  // if CY: skipped
        mem[35] = mov(5, 2, 2);                  // if EQ: done
        mem[36] = st(6, 4);
        mem[37] = st(6, 5);
        mem[38] = ldi(3);                mem[39] = 16'h0030;
        mem[40] = mov(7, 3, 1);                  // jump if CY: not taken
        mem[41] = mov(7, 3, 2);                  // jump if EQ: taken
        mem[48] = st(6, 2);
        mem[49] = ldi(7);                mem[50] = 16'h0040;
        mem[64] = ldi(5);                mem[65] = 16'hFFFF;
        mem[66] = ins(0, 0, 5, 0, 0, 0, 'h00);   // wrap: CY=1 EQ=1
        mem[67] = st(6, 5);
        mem[68] = mov(4, 1, 1);                  // if CY: done
        mem[69] = st(6, 4);
        mem[70] = ldi(7);                mem[71] = 16'h0046;   // self loop
    endtask

    initial begin
        load_program();
        expect_st(16'h0080, 16'h2143, "R5 add B");
        expect_st(16'h0081, 16'h0204, "R6 and");
        expect_st(16'h0082, 16'h1F3F, "R6 or");
        expect_st(16'h0083, 16'h1D3B, "R6 xor");
        expect_st(16'h0084, 16'hE2C4, "R6 not");
        expect_st(16'h0085, 16'h0325, "R5 subtract");
        expect_st(16'h0086, 16'h0F10, "R7 cin from CY");
        expect_st(16'h0087, 16'h0F11, "R8 flag hold");
        expect_st(16'h0088, 16'h0F12, "R7 cin from EQ and zero");
        expect_st(16'h0089, 16'h1234, "R9 compare keeps A");
        expect_st(16'h008A, 16'h0F12, "R9 write gated by CY");
        expect_st(16'h008B, 16'h0F0F, "R9 write gated by EQ");
        expect_st(16'h008C, 16'h0F0F, "R10 conditional jump");
        expect_st(16'h008D, 16'h0000, "R3 load jump then R8 carry out");
        expect_st(16'h008E, 16'h1234, "R8 CY latched on carry");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 fetch phase in reset", {15'd0, fetch_phase}, 16'd1);
        rst = 1'b0;
        check("R1 fetch phase", {15'd0, fetch_phase}, 16'd1);
        check("R1 address", mem_addr, 16'h0000);
        check("R1 strobes", {14'd0, mem_rd, mem_wr}, 16'b10);
        @(negedge clk);
        check("R2 execute phase", {15'd0, fetch_phase}, 16'd0);
        check("R2 R7 incremented", mem_addr, 16'h0001);
        @(negedge clk);
        check("R2 next fetch", mem_addr, 16'h0002);

        while (q.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
        check("R4 all stores seen", 16'(q.size()), 16'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule